// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Counter

This block keeps a raw microsecond count for system software, using the reference clock it is clocked by. A fractional prescaler adds a programmable increment to an accumulator on every enabled reference cycle. Each time the accumulator reaches a programmable limit, the prescaler emits a one-cycle microsecond tick, and the tick advances a free-running counter by one.

The step ratio is (dividend+1)/(divisor+1). A reference such as 12.8 MHz or 19.2 MHz, which no whole divider can bring to 1 MHz, therefore still averages exactly 1 MHz. The count is presented raw through a small word-addressed register port. Any widening of the count beyond its native width is done by software. A separate enable input freezes all counting while it is low.

Top module: `usec_frac_timer`

## Requirements
- R1: The configuration word is read and written at byte offset 0x4. Bits [15:8] hold the dividend and bits [7:0] hold the divisor. Both fields are stored as n-1, so a field value of 0 stands for a factor of 1. Bits [31:16] always read back as zero. For example, 0x043F gives a ratio of 5/64.
- R2: After reset the counter reads 0, the configuration reads 0x0000000C (one tick every 13 enabled cycles), and `usec_tick` is low.
- R3: While the dividend is not greater than the divisor, N enabled cycles that follow a configuration write advance the counter by floor(N·(dividend+1)/(divisor+1)).
- R4: `usec_tick` is high for single cycles only. The counter rises by exactly one on the clock edge that ends each cycle in which `usec_tick` is high, and it does not change at any other edge.
- R5: While `tmr_en` is low, `usec_tick` stays low and both the accumulator and the counter keep their values.
- R6: A configuration write clears the accumulator. It leaves the counter unchanged, and no tick is issued in the cycle of the write.
- R7: The counter wraps from its all-ones value to zero, and no flag is raised.
- R8: Writes to offset 0x0 and to unmapped offsets change neither the counter nor the configuration. Unmapped offsets read as zero.
- R9: When the dividend is greater than the divisor, a tick is issued on every enabled cycle that is not a configuration write. This means at most one tick per reference cycle.
- R10: The counter value is read raw, zero-extended to 32 bits, at offset 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer clock enable; all counting stops while it is low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| usec_tick | output | 1 | One-cycle pulse for each microsecond step |

## Verification
The read port is combinational, so a register read is due in the same cycle that the address is presented. The bench samples it 1 ns after a falling edge. The accumulator and the counter each update on the rising edge that ends an enabled cycle, and `usec_tick` is visible during the cycle before the edge that counts it. The bench therefore drives every input at a falling edge and samples the tick once per cycle, just after that falling edge, before the rising edge that consumes it. Counter reads are taken only after the last enabled edge of a run has passed. A configuration write takes effect at the end of its own cycle, so each run of N enabled cycles starts from a cleared accumulator, and floor(N·(dividend+1)/(divisor+1)) applies exactly.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

  // Byte offsets of the two registers; software depends on these.
  localparam int unsigned OFS_COUNT = 0;
  localparam int unsigned OFS_CFG   = 4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CFG   = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/usec_presc.sv
// Fractional prescaler: the accumulator gains (mul+1) per enabled cycle and
// gives back (div+1) whenever it reaches that limit, issuing one tick.
module usec_presc #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [FIELD_W-1:0] mul_f,
  input  logic [FIELD_W-1:0] div_f,
  output logic               tick,
  output logic [FIELD_W:0]   acc_o
);
  localparam int unsigned ACC_W = FIELD_W + 1;

  // Factor stored as n-1 -> actual factor, one bit wider.
  function automatic logic [ACC_W-1:0] factor(input logic [FIELD_W-1:0] f);
    return {1'b0, f} + ACC_W'(1);
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] lim;
  logic [ACC_W-1:0] sum;
  logic             bad_ratio;
  logic             reach;

  always_comb begin
    inc       = factor(mul_f);
    lim       = factor(div_f);
    sum       = acc_q + inc;
    bad_ratio = (mul_f > div_f);
    reach     = (sum >= lim);
    tick      = en && !clr && (bad_ratio || reach);
  end

  always_comb begin
    if (clr)            acc_d = '0;
    else if (!en)       acc_d = acc_q;
    else if (bad_ratio) acc_d = '0;
    else if (reach)     acc_d = sum - lim;
    else                acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/usec_count.sv
// Free-running counter, one step per tick, silent wrap.
module usec_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/usec_regs.sv
// Register decode: raw counter view and the ratio configuration word.
module usec_regs
  import usec_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [2*FIELD_W-1:0] CFG_RST = 16'h000C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     cnt,
  output logic [DATA_W-1:0]    rdata,
  output logic [2*FIELD_W-1:0] cfg,
  output logic                 cfg_wr
);
  localparam int unsigned CFG_W = 2 * FIELD_W;

  reg_sel_e         sel;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    if (addr == ADDR_W'(OFS_COUNT))    sel = SEL_COUNT;
    else if (addr == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
    else                               sel = SEL_NONE;
  end

  assign cfg_wr = wr && (sel == SEL_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_wr) cfg_q <= wdata[CFG_W-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_COUNT: rdata = DATA_W'(cnt);
      SEL_CFG:   rdata = DATA_W'(cfg_q);
      default:   rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/usec_frac_timer.sv
// Top: register port, fractional prescaler and microsecond counter.
module usec_frac_timer #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              usec_tick
);
  localparam int unsigned CFG_W = 2 * FIELD_W;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [FIELD_W:0] acc_q;
  logic             tick_w;

  usec_regs #(
    .CNT_W(CNT_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CFG_RST(CFG_W'(16'h000C))
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cnt(cnt_q), .rdata(reg_rdata),
    .cfg(cfg_q), .cfg_wr(cfg_wr)
  );

  usec_presc #(.FIELD_W(FIELD_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(tmr_en), .clr(cfg_wr),
    .mul_f(cfg_q[CFG_W-1:FIELD_W]), .div_f(cfg_q[FIELD_W-1:0]),
    .tick(tick_w), .acc_o(acc_q)
  );

  usec_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .step(tick_w), .cnt(cnt_q)
  );

  assign usec_tick = tick_w;
endmodule

// File: rtl/usec_frac_timer_chk.sv
module usec_frac_timer_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tmr_en,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               usec_tick,
  input logic [CNT_W-1:0]   cnt_q,
  input logic [2*FIELD_W-1:0] cfg_q,
  input logic [FIELD_W:0]   acc_q,
  input logic               cfg_wr
);
  logic ratio_bad;
  assign ratio_bad = cfg_q[2*FIELD_W-1:FIELD_W] > cfg_q[FIELD_W-1:0];

  // R4 R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usec_tick |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !usec_tick |=> $stable(cnt_q));

  // R5
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |-> !usec_tick);

  // R5
  idle_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !reg_wr) |=> $stable(acc_q));

  // R6
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (acc_q == '0));

  // R6
  cfg_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> !usec_tick);

  // R8
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> $stable(cfg_q));

  // R9
  bad_ratio_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_bad && tmr_en && !cfg_wr) |-> usec_tick);
endmodule

bind usec_frac_timer usec_frac_timer_chk #(
  .CNT_W(CNT_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .usec_tick(usec_tick), .cnt_q(cnt_q),
  .cfg_q(cfg_q), .acc_q(acc_q), .cfg_wr(cfg_wr)
);

// File: tb/usec_frac_timer_bench.sv
`timescale 1ns/1ps
module usec_frac_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] small_rdata;
  logic        usec_tick;
  logic        small_tick;

  int unsigned checks = 0;
  int unsigned failures = 0;
  int unsigned exp_cnt = 0;
  int unsigned tick_seen = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  usec_frac_timer u_usec_frac_timer (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .usec_tick(usec_tick)
  );

  // Same stimulus, 8-bit counter, so the wrap can be reached.
  usec_frac_timer #(.CNT_W(8)) u_small (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(small_rdata),
    .usec_tick(small_tick)
  );

  // {config word, enabled cycles}
  localparam logic [31:0] VEC [9] = '{
    {16'h000B, 16'd120}, {16'h043F, 16'd640}, {16'h045F, 16'd960},
    {16'h04BF, 16'd1920}, {16'h000C, 16'd130}, {16'h043F, 16'd100},
    {16'h0000, 16'd7},   {16'h0100, 16'd9},   {16'h0503, 16'd33}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic write_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1 if (usec_tick) tick_seen++;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // n cycles with the given enable; counts ticks seen before each edge.
  task automatic run(input int n, input logic en);
    @(negedge clk);
    tmr_en = en;
    for (int i = 0; i < n; i++) begin
      #1 if (usec_tick) tick_seen++;
      @(negedge clk);
    end
    tmr_en = 1'b0;
  endtask

  function automatic int unsigned model(input logic [15:0] c, input int unsigned n);
    int unsigned m = int'(c[15:8]) + 1;
    int unsigned d = int'(c[7:0]) + 1;
    if (m > d) return n;
    return (n * m) / d;
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R2: reset state
    #1 check("R2 tick", {31'b0, usec_tick}, 32'd0);
    read_reg(4'h0, v); check("R2 count", v, 32'd0);
    read_reg(4'h4, v); check("R2 cfg", v, 32'h0000000C);
    rst_n = 1'b1;
    // R3: default ratio 1/13
    tick_seen = 0;
    run(26, 1'b1); exp_cnt += 2;
    read_reg(4'h0, v); check("R3 default rate", v, exp_cnt);
    check("R4 ticks vs steps", tick_seen, 32'd2);

    // Table walk: R1 R3 R9 R4 R10
    for (int k = 0; k < 9; k++) begin
      logic [15:0] c = VEC[k][31:16];
      int unsigned n = int'(VEC[k][15:0]);
      int unsigned inc = model(c, n);
      write_reg(4'h4, {16'h0000, c});
      read_reg(4'h4, v); check("R1 cfg readback", v, {16'h0000, c});
      tick_seen = 0;
      run(n, 1'b1);
      exp_cnt += inc;
      read_reg(4'h0, v);
      if (c[15:8] > c[7:0]) check("R9 bad ratio count", v, exp_cnt);
      else                  check("R3 R10 ratio count", v, exp_cnt);
      check("R4 tick pulses", tick_seen, inc);
    end

    // R1: upper bits dropped
    write_reg(4'h4, 32'hABCD_000C);
    read_reg(4'h4, v); check("R1 upper bits zero", v, 32'h0000000C);

    // R5: enable low freezes everything
    tick_seen = 0;
    run(6, 1'b1);               // acc = 6 of 13
    run(50, 1'b0);
    read_reg(4'h0, v); check("R5 count hold", v, exp_cnt);
    check("R5 no tick", tick_seen, 32'd0);
    run(7, 1'b1); exp_cnt += 1; // 6+7 = 13 -> one step
    read_reg(4'h0, v); check("R5 acc kept", v, exp_cnt);

    // R6: config write clears accumulator, counter kept
    run(12, 1'b1);              // acc = 12, no step
    write_reg(4'h4, 32'h0000000C);
    read_reg(4'h0, v); check("R6 count kept", v, exp_cnt);
    tick_seen = 0;
    run(12, 1'b1);
    read_reg(4'h0, v); check("R6 acc cleared", v, exp_cnt);
    run(1, 1'b1); exp_cnt += 1;
    read_reg(4'h0, v); check("R6 step after 13", v, exp_cnt);
    // R6: write while enabled and at the limit gives no tick
    run(12, 1'b1);
    @(negedge clk);
    tmr_en = 1'b1; reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h0000000C;
    #1 check("R6 no tick on write", {31'b0, usec_tick}, 32'd0);
    @(negedge clk);
    reg_wr = 1'b0; tmr_en = 1'b0;
    read_reg(4'h0, v); check("R6 no step on write", v, exp_cnt);

    // R8: writes to counter and unmapped offsets ignored
    write_reg(4'h0, 32'h1234_5678);
    read_reg(4'h0, v); check("R8 count write", v, exp_cnt);
    read_reg(4'h4, v); check("R8 cfg untouched", v, 32'h0000000C);
    write_reg(4'h8, 32'h0000_0100);
    read_reg(4'h4, v); check("R8 unmapped write", v, 32'h0000000C);
    read_reg(4'h8, v); check("R8 unmapped read", v, 32'd0);

    // R7: wrap on the 8-bit instance
    write_reg(4'h4, 32'h0000_0100);
    run(300, 1'b1); exp_cnt += 300;
    read_reg(4'h0, v); check("R7 wide count", v, exp_cnt);
    check("R7 small wrap", small_rdata, exp_cnt % 256);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule